// File: doc/BRIEF.md
# Selectable Reference and Time-Base Generator

This block runs from the tuner's crystal clock, which is either 4.5 MHz or 7.2 MHz as chosen by a crystal-select input. It divides that clock down to one of twelve phase-comparison reference rates, chosen by a 4-bit rate code. It emits one single-cycle pulse per reference period. A code outside the twelve valid values puts the divider into an inhibit state, and no pulses are produced. A new code or crystal selection is applied only when the current reference period ends, so the reference period never takes a value that belongs to neither setting.

The block also produces a slow time-base square wave at 8 Hz. The wave is high for two fifths of each period, and the period is counted exactly in crystal cycles. When the time-base enable is set, the wave drives the first general output port pin in place of the stored port data bit. When the enable is clear, the pin carries the stored bit. The 8 Hz period is a parameter, so a system can also run a faster time base.

Top module: `refgen_top`

## Requirements
- R1: While reset is asserted and right after it, `ref_pulse` and `port1_o` are 0.
- R2: With `xtal_sel`=0 (4.5 MHz), the codes 0 to 11 give the periods 45, 90, 180, 300, 360, 450, 500, 720, 900, 1440, 1500 and 4500 crystal cycles. These are 100, 50, 25, 15, 12.5, 10, 9, 6.25, 5, 3.125, 3 and 1 kHz.
- R3: With `xtal_sel`=1 (7.2 MHz), the codes 0 to 11 give the periods 72, 144, 288, 480, 576, 720, 800, 1152, 1440, 2304, 2400 and 7200 crystal cycles, for the same rates as in R2.
- R4: Codes 12 to 15 select the inhibit state, and `ref_pulse` stays 0 there. A running divider enters inhibit at the end of its current period.
- R5: Each reference pulse is exactly one clock wide. While the setting is unchanged, consecutive pulses are exactly one period apart.
- R6: A change of `ref_code` or `xtal_sel` takes effect only at the end of the current reference period.
- R7: When a valid code is applied in the inhibit state, it is loaded on the next clock edge. The first pulse follows one full period after that edge.
- R8: The time base is a free-running counter started at reset. Its period is crystal/8 cycles for the selected crystal. It is high for the first 2/5 of each period and low for the rest.
- R9: While `tb_en`=1, `port1_o` shows the time base one clock late, and `port1_d` has no effect on it.
- R10: While `tb_en`=0, `port1_o` takes the value of `port1_d` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_sel | input | 1 | Crystal select: 0 = 4.5 MHz, 1 = 7.2 MHz |
| ref_code | input | 4 | Reference rate code, 0 to 11 valid, 12 to 15 inhibit |
| tb_en | input | 1 | Time-base enable for output port 1 |
| port1_d | input | 1 | Stored data bit for output port 1 |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| port1_o | output | 1 | Output port 1 pin value |

## Verification
The embedded properties check the following on every cycle:
- The divider count stays inside the active period, and pulses are always one cycle wide.
- The active divisor does not move except at a period boundary, and a boundary taken with an invalid code is followed by silence.
- The port pin follows either the data bit or the wave, depending on the enable.

The actual period lengths, how each rate code maps to each crystal, the 2/5 duty and the timing of mid-period setting changes are only shown by the bench's scenarios. The bench runs every code on both crystals and compares against its own cycle model.

// File: rtl/refgen_pkg.sv
package refgen_pkg;

  localparam int unsigned NUM_RATES = 12;

  // Reference rate in Hz for each valid code; 1 for unused codes so that
  // constant divisions never divide by zero.
  function automatic int unsigned rate_hz(input logic [3:0] code);
    case (code)
      4'd0:    rate_hz = 100000;
      4'd1:    rate_hz = 50000;
      4'd2:    rate_hz = 25000;
      4'd3:    rate_hz = 15000;
      4'd4:    rate_hz = 12500;
      4'd5:    rate_hz = 10000;
      4'd6:    rate_hz = 9000;
      4'd7:    rate_hz = 6250;
      4'd8:    rate_hz = 5000;
      4'd9:    rate_hz = 3125;
      4'd10:   rate_hz = 3000;
      4'd11:   rate_hz = 1000;
      default: rate_hz = 1;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
  import refgen_pkg::*;
#(
  parameter int unsigned XTAL_A_HZ = 4500000,
  parameter int unsigned XTAL_B_HZ = 7200000,
  parameter int unsigned DIV_W     = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_sel,
  input  logic [3:0] code,
  output logic       ref_pulse
);

  logic [DIV_W-1:0] tab_a [16];
  logic [DIV_W-1:0] tab_b [16];

  genvar g;
  generate
    for (g = 0; g < 16; g++) begin : g_tab
      if (g < NUM_RATES) begin : g_used
        assign tab_a[g] = DIV_W'(XTAL_A_HZ / rate_hz(4'(g)));
        assign tab_b[g] = DIV_W'(XTAL_B_HZ / rate_hz(4'(g)));
      end else begin : g_unused
        assign tab_a[g] = '0;
        assign tab_b[g] = '0;
      end
    end
  endgenerate

  logic             run_q, run_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             code_ok;
  logic [DIV_W-1:0] lut_div;
  logic             at_end;
  logic             st_en;

  assign code_ok = (code < 4'(NUM_RATES));
  assign lut_div = xtal_sel ? tab_b[code] : tab_a[code];
  assign at_end  = run_q && (cnt_q == div_q - 1'b1);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    div_d = div_q;
    st_en = 1'b1;
    if (!run_q) begin
      st_en = code_ok;
      if (code_ok) begin
        run_d = 1'b1;
        div_d = lut_div;
        cnt_d = '0;
      end
    end else if (at_end) begin
      cnt_d = '0;
      div_d = lut_div;
      run_d = code_ok;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= '0;
    end else if (st_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign ref_pulse = at_end;

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < div_q));

  assert_pulse_one_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  assert_div_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_end) |=> $stable(div_q));

  assert_inhibit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !code_ok) |=> (!ref_pulse && !run_q));

endmodule

// File: rtl/timebase_gen.sv
module timebase_gen #(
  parameter int unsigned PER_A = 562500,
  parameter int unsigned PER_B = 900000,
  parameter int unsigned TB_W  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_sel,
  output logic tb_wave
);

  localparam int unsigned HI_A = (PER_A * 2) / 5;
  localparam int unsigned HI_B = (PER_B * 2) / 5;
  localparam int unsigned PER_MAX = (PER_A > PER_B) ? PER_A : PER_B;

  logic [TB_W-1:0] cnt_q, cnt_d;
  logic [TB_W-1:0] last_idx;
  logic [TB_W-1:0] hi_len;

  assign last_idx = xtal_sel ? TB_W'(PER_B - 1) : TB_W'(PER_A - 1);
  assign hi_len   = xtal_sel ? TB_W'(HI_B) : TB_W'(HI_A);

  always_comb begin
    if (cnt_q >= last_idx) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tb_wave = (cnt_q < hi_len);

  assert_tb_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TB_W'(PER_MAX));

  assert_tb_starts_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> tb_wave);

endmodule

// File: rtl/refgen_top.sv
module refgen_top
  import refgen_pkg::*;
#(
  parameter int unsigned XTAL_A_HZ = 4500000,
  parameter int unsigned XTAL_B_HZ = 7200000,
  parameter int unsigned TB_HZ     = 8,
  parameter int unsigned TB_PER_A  = XTAL_A_HZ / TB_HZ,
  parameter int unsigned TB_PER_B  = XTAL_B_HZ / TB_HZ
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_sel,
  input  logic [3:0] ref_code,
  input  logic       tb_en,
  input  logic       port1_d,
  output logic       ref_pulse,
  output logic       port1_o
);

  localparam int unsigned MAX_DIV = max2(XTAL_A_HZ, XTAL_B_HZ) / 1000;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned TB_W    = $clog2(max2(TB_PER_A, TB_PER_B) + 1);

  logic tb_wave;
  logic port_q, port_d;

  ref_divider #(
    .XTAL_A_HZ (XTAL_A_HZ),
    .XTAL_B_HZ (XTAL_B_HZ),
    .DIV_W     (DIV_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_sel  (xtal_sel),
    .code      (ref_code),
    .ref_pulse (ref_pulse)
  );

  timebase_gen #(
    .PER_A (TB_PER_A),
    .PER_B (TB_PER_B),
    .TB_W  (TB_W)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_sel (xtal_sel),
    .tb_wave  (tb_wave)
  );

  always_comb begin
    port_d = tb_en ? tb_wave : port1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= 1'b0;
    else        port_q <= port_d;
  end

  assign port1_o = port_q;

  assert_port_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> (port1_o == $past(port1_d)));

  assert_port_shows_tb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tb_en |=> (port1_o == $past(tb_wave)));

endmodule

// File: tb/tb_refgen_top.sv
module tb_refgen_top;

  localparam int TBA = 50;
  localparam int TBB = 80;
  localparam int WATCHDOG_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xtal_sel;
  logic [3:0] ref_code;
  logic       tb_en;
  logic       port1_d;
  logic       ref_pulse;
  logic       port1_o;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  refgen_top #(
    .TB_PER_A (TBA),
    .TB_PER_B (TBB)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_sel  (xtal_sel),
    .ref_code  (ref_code),
    .tb_en     (tb_en),
    .port1_d   (port1_d),
    .ref_pulse (ref_pulse),
    .port1_o   (port1_o)
  );

  // Expected period lengths from R2 / R3
  function automatic int div_of(input int code, input bit sel);
    int a [12] = '{45, 90, 180, 300, 360, 450, 500, 720, 900, 1440, 1500, 4500};
    int b [12] = '{72, 144, 288, 480, 576, 720, 800, 1152, 1440, 2304, 2400, 7200};
    return sel ? b[code] : a[code];
  endfunction

  // Behavioural reference model
  bit m_run;
  int m_cnt, m_div, m_tb;
  bit m_port;

  always @(posedge clk or negedge rst_n) begin
    int per;
    bit wave, endp, ok;
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_div = 0; m_tb = 0; m_port = 0;
    end else begin
      per  = xtal_sel ? TBB : TBA;
      wave = (m_tb < (per * 2) / 5);
      endp = m_run && (m_cnt == m_div - 1);
      ok   = (ref_code < 12);
      m_port = tb_en ? wave : port1_d;
      m_tb = (m_tb >= per - 1) ? 0 : m_tb + 1;
      if (!m_run) begin
        if (ok) begin m_run = 1; m_div = div_of(ref_code, xtal_sel); m_cnt = 0; end
      end else if (endp) begin
        m_cnt = 0;
        if (ok) m_div = div_of(ref_code, xtal_sel);
        m_run = ok;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    bit exp_p;
    if (!done) begin
      exp_p = m_run && (m_cnt == m_div - 1);
      n_cmp++;
      if (ref_pulse !== exp_p) begin
        n_bad++;
        $display("FAIL %s ref_pulse actual=%b expected=%b at %0t", tag, ref_pulse, exp_p, $time);
      end
      n_cmp++;
      if (port1_o !== m_port) begin
        n_bad++;
        $display("FAIL %s port1_o actual=%b expected=%b at %0t", tag, port1_o, m_port, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    cyc(WATCHDOG_CYC);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    finish_run();
  end

  initial begin
    rst_n = 0; xtal_sel = 0; ref_code = 4'd15; tb_en = 0; port1_d = 1;
    tag = "R1 reset";
    cyc(5);
    rst_n = 1;
    cyc(3);

    tag = "R4 inhibit codes";
    for (int c = 12; c < 16; c++) begin ref_code = 4'(c); cyc(60); end

    tag = "R2 R5 R7 xtal 4.5";
    xtal_sel = 0;
    for (int c = 0; c < 12; c++) begin
      ref_code = 4'(c);
      cyc(2 * div_of(c, 0) + 10);
    end

    tag = "R3 R5 xtal 7.2";
    xtal_sel = 1;
    for (int c = 0; c < 12; c++) begin
      ref_code = 4'(c);
      cyc(2 * div_of(c, 1) + 10);
    end

    tag = "R4 running to inhibit";
    ref_code = 4'd13;
    cyc(7300);

    tag = "R6 R7 mid-period change";
    xtal_sel = 0; ref_code = 4'd0;
    cyc(20);
    ref_code = 4'd3;
    cyc(17);
    xtal_sel = 1;
    cyc(40);
    ref_code = 4'd1;
    cyc(1000);

    tag = "R8 R9 time base";
    tb_en = 1;
    for (int i = 0; i < 600; i++) begin
      port1_d = 1'($urandom_range(0, 1));
      if (i == 300) xtal_sel = 0;
      if (i == 450) xtal_sel = 1;
      cyc(1);
    end

    tag = "R10 R9 port data";
    for (int i = 0; i < 600; i++) begin
      port1_d = 1'($urandom_range(0, 1));
      tb_en   = (i % 97) > 60;
      cyc(1);
    end

    tag = "R1 reset again";
    rst_n = 0;
    cyc(3);
    finish_run();
  end

endmodule